// File: doc/BRIEF.md
# Wrapping burst column address generator

This block turns one burst request into a stream of column addresses for a synchronous DRAM read or write. A request carries a starting column, a three-bit burst-length code and an ordering bit. From the following clock on, the block presents one column per cycle with a valid strobe and marks the final beat with a last flag. The same length and ordering settings serve read bursts and write bursts alike.

Every beat of a burst stays inside an aligned window of columns as wide as the burst. The column bits above the window are held at the start column's value, and the low bits step through the window either by modular increment (sequential) or by XOR of the beat index into the start offset (interleaved). When the sequence reaches the top of the window it wraps to the bottom of the same window. A request that carries a reserved length code yields a one-cycle error pulse and no addresses.

Top module: `burst_col_gen`

## Requirements
- R1: Length code 3'b001 yields exactly 2 beats, 3'b010 yields 4 and 3'b011 yields 8, with `valid_o` high on consecutive cycles for that many beats and low afterwards unless a new burst begins.
- R2: A start taken at clock edge n puts beat 0 on `col_o` with `valid_o` high from edge n, and beat 0 equals the start column.
- R3: With `interleave_i` = 0 (sequential), beat i carries low bits equal to (start low bits + i) modulo the burst length.
- R4: With `interleave_i` = 1 (interleaved), beat i carries low bits equal to (start low bits) XOR i.
- R5: The low bits are bit 0 for length 2, bits [1:0] for length 4 and bits [2:0] for length 8; every column bit above them equals the start column's bit for the whole burst.
- R6: `last_o` is high together with the final beat of a burst and at no other time.
- R7: A start taken with a reserved code (3'b000, 3'b100 to 3'b111) raises `err_o` for exactly one cycle from the next edge and produces no beat.
- R8: A start presented while a beat that is not the last is on the outputs is ignored: the current burst continues unchanged and no error is raised.
- R9: A start presented while the last beat is on the outputs is taken, so the new burst's beat 0 follows the old last beat with no gap.
- R10: While reset is high, `valid_o`, `last_o` and `err_o` are low and `col_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request, sampled on each rising edge |
| start_col_i | input | COL_W | Starting column of the requested burst |
| len_code_i | input | 3 | Burst-length code (001, 010, 011 valid) |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Current beat is a real address |
| last_o | output | 1 | Current beat is the final one of the burst |
| err_o | output | 1 | One-cycle pulse for a refused reserved-code request |

## Verification
The embedded properties assume the request inputs are stable across each sampling edge and that length and ordering are only meaningful in the cycle where a start is taken; the stepping checks rely on no other agent disturbing the held burst state. The stimulus drives every input on the falling edge, raises the start strobe for a single cycle, and changes the length and ordering only together with a start. The sweep covers all eight length codes, both orderings and every start offset within the largest window, each with a different pattern in the upper column bits, plus directed cases for a start during a burst and a start on the last beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;
  localparam int MAX_LG     = 3;
  localparam int LG_W       = 2;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;

  typedef struct packed {
    logic            ok;
    logic [LG_W-1:0] lg;
  } len_info_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] code_i,
  output len_info_t             info_o
);
  always_comb begin
    case (code_i)
      3'b001:  info_o = '{ok: 1'b1, lg: 2'd1};
      3'b010:  info_o = '{ok: 1'b1, lg: 2'd2};
      3'b011:  info_o = '{ok: 1'b1, lg: 2'd3};
      default: info_o = '{ok: 1'b0, lg: 2'd0};
    endcase
  end
endmodule

// File: rtl/col_offset_mix.sv
module col_offset_mix
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int IDX_W = MAX_LG
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LG_W-1:0]  lg_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] win_mask;
  logic [COL_W-1:0] idx_ext;
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_xor;

  always_comb begin
    win_mask = (COL_W'(1) << lg_i) - COL_W'(1);
    idx_ext  = COL_W'(idx_i);
    low_seq  = (base_i + idx_ext) & win_mask;
    low_xor  = (base_i ^ idx_ext) & win_mask;
    col_o    = (base_i & ~win_mask) |
               ((order_i == ORDER_XOR) ? low_xor : low_seq);
  end

  always_comb begin
    a_upper_kept_r5: assert ((col_o & ~win_mask) == (base_i & ~win_mask));
  end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int IDX_W = MAX_LG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  len_info_t        info_i,
  input  order_e           order_i,
  input  logic [COL_W-1:0] next_col_i,
  output logic [COL_W-1:0] base_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LG_W-1:0]  lg_o,
  output order_e           order_o,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] base_q;
  logic [IDX_W-1:0] idx_q;
  logic [LG_W-1:0]  lg_q;
  order_e           ord_q;
  logic [COL_W-1:0] col_q;
  logic             valid_q;
  logic             last_q;
  logic             err_q;
  logic             take;
  logic [IDX_W-1:0] last_idx;
  logic [COL_W-1:0] win_mask;

  always_comb begin
    take     = start_i && (!valid_q || last_q);
    last_idx = IDX_W'(((IDX_W+1)'(1) << lg_q) - (IDX_W+1)'(1));
    win_mask = (COL_W'(1) << lg_q) - COL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      idx_q   <= '0;
      lg_q    <= '0;
      ord_q   <= ORDER_SEQ;
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take && !info_i.ok;
      if (take && info_i.ok) begin
        base_q  <= start_col_i;
        lg_q    <= info_i.lg;
        ord_q   <= order_i;
        idx_q   <= IDX_W'(1);
        col_q   <= start_col_i;
        valid_q <= 1'b1;
        last_q  <= 1'b0;
      end else if (valid_q && !last_q) begin
        col_q  <= next_col_i;
        last_q <= (idx_q == last_idx);
        idx_q  <= idx_q + IDX_W'(1);
      end else begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
    end
  end

  assign base_o  = base_q;
  assign idx_o   = idx_q;
  assign lg_o    = lg_q;
  assign order_o = ord_q;
  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign err_o   = err_q;

  p_last_in_beat_r6: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_err_no_beat_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && (!valid_o || last_o) && info_i.ok)
      |=> (valid_o && col_o == $past(start_col_i)));

  p_block_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> ((col_o & ~win_mask) == ($past(col_o) & ~win_mask)));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && ord_q == ORDER_SEQ)
      |=> (((col_o - $past(col_o)) & win_mask) == COL_W'(1)));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && start_i) |=> (valid_o && !err_o));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  localparam int IDX_W = MAX_LG;

  len_info_t        info;
  logic [COL_W-1:0] base;
  logic [IDX_W-1:0] idx;
  logic [LG_W-1:0]  lg;
  order_e           ord;
  logic [COL_W-1:0] next_col;

  burst_len_decode u_dec (
    .code_i (len_code_i),
    .info_o (info)
  );

  col_offset_mix #(.COL_W(COL_W), .IDX_W(IDX_W)) u_mix (
    .base_i  (base),
    .idx_i   (idx),
    .lg_i    (lg),
    .order_i (ord),
    .col_o   (next_col)
  );

  burst_beat_seq #(.COL_W(COL_W), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .info_i      (info),
    .order_i     (order_e'(interleave_i)),
    .next_col_i  (next_col),
    .base_o      (base),
    .idx_o       (idx),
    .lg_o        (lg),
    .order_o     (ord),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!valid_o && !last_o && !err_o));
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             interleave_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .col_o        (col_o),
    .valid_o      (valid_o),
    .last_o       (last_o),
    .err_o        (err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int code_lg(input logic [2:0] code);
    case (code)
      3'b001:  return 1;
      3'b010:  return 2;
      3'b011:  return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int lg, input bit intl, input int i);
    int len  = 1 << lg;
    int mask = len - 1;
    int low  = intl ? ((s ^ i) & mask) : (((s & mask) + i) % len);
    return (s & ~mask) | low;
  endfunction

  task automatic drive_start(input int s, input logic [2:0] code, input bit intl);
    start_col_i  = COL_W'(s);
    len_code_i   = code;
    interleave_i = intl;
    start_i      = 1'b1;
  endtask

  // Sample beats i0..L-1 of a burst whose beat i0 is on the outputs now.
  task automatic follow(input int s, input int lg, input bit intl, input int i0);
    int len = 1 << lg;
    for (int i = i0; i < len; i++) begin
      if (i != i0) @(negedge clk);
      chk(valid_o == 1'b1, "R1 valid during burst", int'(valid_o), 1);
      chk(int'(col_o) == exp_col(s, lg, intl, i),
          intl ? "R4/R5 interleaved column" : "R3/R5 sequential column",
          int'(col_o), exp_col(s, lg, intl, i));
      chk(last_o == (i == len - 1), "R6 last flag", int'(last_o), int'(i == len - 1));
    end
  endtask

  task automatic run_burst(input int s, input logic [2:0] code, input bit intl);
    int lg = code_lg(code);
    @(negedge clk);
    drive_start(s, code, intl);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (lg == 0) begin
      chk(err_o == 1'b1, "R7 error pulse", int'(err_o), 1);
      chk(valid_o == 1'b0, "R7 no beat", int'(valid_o), 0);
      @(negedge clk);
      chk(err_o == 1'b0 && valid_o == 1'b0, "R7 pulse one cycle",
          int'({err_o, valid_o}), 0);
    end else begin
      chk(int'(col_o) == s, "R2 beat 0 is start column", int'(col_o), s);
      chk(err_o == 1'b0, "R7 no error on valid code", int'(err_o), 0);
      follow(s, lg, intl, 0);
      @(negedge clk);
      chk(valid_o == 1'b0 && last_o == 1'b0, "R1 burst ends after length",
          int'({valid_o, last_o}), 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(valid_o == 0 && last_o == 0 && err_o == 0 && col_o == '0,
        "R10 reset state", int'({valid_o, last_o, err_o}) + int'(col_o), 0);
    rst = 1'b0;

    // Sweep all codes, both orders, every offset in the widest window.
    for (int code = 0; code < 8; code++) begin
      for (int intl = 0; intl < 2; intl++) begin
        for (int off = 0; off < 8; off++) begin
          int s = ((((code * 37) + (off * 13) + (intl * 101)) << 3) | off) & 10'h3FF;
          run_burst(s, 3'(code), bit'(intl));
        end
      end
    end

    // R8: start during a burst is ignored.
    @(negedge clk);
    drive_start(10'h2A5, 3'b011, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk(int'(col_o) == 10'h2A5, "R2 beat 0 before ignored start", int'(col_o), 10'h2A5);
    drive_start(10'h011, 3'b001, 1'b1);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b0, "R8 no error on ignored start", int'(err_o), 0);
    chk(int'(col_o) == exp_col(10'h2A5, 3, 1'b0, 1), "R8 burst continues",
        int'(col_o), exp_col(10'h2A5, 3, 1'b0, 1));
    follow(10'h2A5, 3, 1'b0, 1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R8 ignored start left no burst", int'(valid_o), 0);

    // R9: start on the last beat chains with no gap.
    @(negedge clk);
    drive_start(10'h1F3, 3'b001, 1'b0);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    follow(10'h1F3, 1, 1'b0, 0);
    drive_start(10'h0C6, 3'b010, 1'b1);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b1 && int'(col_o) == 10'h0C6, "R9 back-to-back beat 0",
        int'(col_o), 10'h0C6);
    follow(10'h0C6, 2, 1'b1, 0);
    drive_start(10'h3FF, 3'b111, 1'b0);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1 && valid_o == 1'b0, "R7 reserved code on last beat",
        int'({err_o, valid_o}), 2);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule